// File: doc/BRIEF.md
# Triggered Circular Capture Controller

This block sequences the writes of a two-channel sampler into a pair of circular buffers that share one address. Once software arms it, every decimated sample (marked by a sample-valid strobe) is written to both channel buffers at the current write pointer, which then advances and wraps at the buffer size. The buffers therefore always hold the most recent history.

When a trigger qualifier arrives while the controller is armed, the current write address is latched as the trigger pointer and a post-trigger counter is loaded from a programmed delay. Capture goes on for exactly that many further decimated samples and then stops. Software then reads the trigger pointer and finds both the history before the trigger and the samples after it. A separate reset request returns the sequencer to idle and clears both pointers. Both pointers can be read at any time.

Top module: `capture_ctrl`

## Requirements
- R1: After reset the controller is idle, `wr_en_o` is 0, `cur_ptr_o` and `trig_ptr_o` are 0 and `done_o` is 0.
- R2: `wr_en_o` is high only in a cycle where `smp_vld_i` is high and the controller is armed or still counting post-trigger samples. In that cycle `wr_addr_o` equals `cur_ptr_o`, and `wr_a_o`/`wr_b_o` carry `ch_a_i`/`ch_b_i`.
- R3: Each write advances `cur_ptr_o` by one in the next cycle, wrapping from 2^ADDR_W-1 to 0. Without a write the pointer holds.
- R4: A `trig_i` pulse while armed makes `trig_ptr_o` equal, from the next cycle, to the value `cur_ptr_o` had in the trigger cycle. A write in that same cycle still takes place.
- R5: After the trigger cycle exactly `delay_i` further writes occur. The remaining count drops only on sample-valid cycles. One cycle after the count is exhausted the controller enters the done state. A delay of 0 gives no write after the trigger cycle.
- R6: `done_o` is 1 while in the done state and stays 1 until an arm pulse. The arm pulse clears it and resumes writing from the current pointer on the following cycle.
- R7: `trig_i` while idle or done is ignored: no write occurs and `trig_ptr_o` is unchanged.
- R8: `wsm_rst_i` suppresses any write in its own cycle. It returns the controller to idle with both pointers 0 and `done_o` 0 on the next cycle, taking priority over `arm_i`.
- R9: `arm_i` while armed or counting post-trigger samples has no effect: the post-trigger count is not reloaded or extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm pulse (configuration bit 0) |
| wsm_rst_i | input | 1 | Write sequencer reset pulse (configuration bit 1) |
| delay_i | input | DLY_W | Post-trigger sample count |
| smp_vld_i | input | 1 | Decimated sample valid strobe |
| ch_a_i | input | DATA_W | Channel A sample |
| ch_b_i | input | DATA_W | Channel B sample |
| trig_i | input | 1 | Trigger qualifier from the trigger unit |
| wr_en_o | output | 1 | Buffer write enable, both channels |
| wr_addr_o | output | ADDR_W | Shared buffer write address |
| wr_a_o | output | DATA_W | Channel A write data |
| wr_b_o | output | DATA_W | Channel B write data |
| cur_ptr_o | output | ADDR_W | Current write pointer |
| trig_ptr_o | output | ADDR_W | Write pointer latched at the trigger |
| done_o | output | 1 | Capture triggered and complete |

## Verification
The bench builds the controller with ADDR_W=4 and DLY_W=8, so the buffer is 16 entries deep. Pointer wrap-around then comes within a few dozen cycles. A post-trigger delay of 20 can run past the whole buffer, which shows that the count, not the address, ends the capture. The 8-bit delay still covers a zero delay and several small delays with gaps in the sample-valid strobe.

// File: rtl/capctl_pkg.sv
package capctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_e;
endpackage

// File: rtl/capctl_seq.sv
module capctl_seq
    import capctl_pkg::*;
#(
    parameter int DLY_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             wsm_rst_i,
    input  logic             trig_i,
    input  logic             smp_vld_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             wr_en_o,
    output logic             trig_hit_o,
    output logic             clr_o,
    output logic             done_o
);
    typedef struct packed {
        cap_state_e       state;
        logic [DLY_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        wr_en_o    = 1'b0;
        trig_hit_o = 1'b0;
        if (wsm_rst_i) begin
            s_d.state = ST_IDLE;
            s_d.cnt   = '0;
        end else begin
            unique case (s_q.state)
                ST_IDLE: begin
                    if (arm_i) s_d.state = ST_ARMED;
                end
                ST_ARMED: begin
                    wr_en_o = smp_vld_i;
                    if (trig_i) begin
                        trig_hit_o = 1'b1;
                        s_d.cnt    = delay_i;
                        s_d.state  = ST_POST;
                    end
                end
                ST_POST: begin
                    if (s_q.cnt == '0) begin
                        s_d.state = ST_DONE;
                    end else if (smp_vld_i) begin
                        wr_en_o = 1'b1;
                        s_d.cnt = s_q.cnt - DLY_W'(1);
                    end
                end
                ST_DONE: begin
                    if (arm_i) s_d.state = ST_ARMED;
                end
                default: s_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign clr_o  = wsm_rst_i;
    assign done_o = (s_q.state == ST_DONE);

    // R2, R7: no write leaves the block while idle or done
    a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_IDLE || s_q.state == ST_DONE) |-> !wr_en_o);

    // R8: reset request always lands in idle
    a_r8_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wsm_rst_i |=> (s_q.state == ST_IDLE));

    // R6: done persists until arm or reset request
    a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_DONE && !arm_i && !wsm_rst_i) |=> (s_q.state == ST_DONE));

    // R5: remaining count only moves on sample-valid cycles
    a_r5_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_POST && !smp_vld_i && !wsm_rst_i) |=> $stable(s_q.cnt));
endmodule

// File: rtl/capctl_ptr.sv
module capctl_ptr #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              trig_hit_i,
    input  logic              clr_i,
    output logic [ADDR_W-1:0] cur_o,
    output logic [ADDR_W-1:0] trig_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] trg;
    } ptr_t;

    ptr_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (clr_i) begin
            p_d.cur = '0;
            p_d.trg = '0;
        end else begin
            if (trig_hit_i) p_d.trg = p_q.cur;
            if (wr_en_i)    p_d.cur = p_q.cur + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '{cur: '0, trg: '0};
        end else begin
            p_q <= p_d;
        end
    end

    assign cur_o  = p_q.cur;
    assign trig_o = p_q.trg;

    // R3: pointer steps by one per write, wrapping naturally
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clr_i) |=> (p_q.cur == $past(p_q.cur) + ADDR_W'(1)));

    // R3: pointer holds without a write
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !clr_i) |=> $stable(p_q.cur));

    // R4: trigger pointer captures the address of the trigger cycle
    a_r4_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit_i && !clr_i) |=> (p_q.trg == $past(p_q.cur)));

    // R7: trigger pointer untouched without a qualified trigger
    a_r7_trig_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_hit_i && !clr_i) |=> $stable(p_q.trg));

    // R8: reset request clears both pointers
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (p_q.cur == '0 && p_q.trg == '0));
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 14,
    parameter int DLY_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              wsm_rst_i,
    input  logic [DLY_W-1:0]  delay_i,
    input  logic              smp_vld_i,
    input  logic [DATA_W-1:0] ch_a_i,
    input  logic [DATA_W-1:0] ch_b_i,
    input  logic              trig_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_a_o,
    output logic [DATA_W-1:0] wr_b_o,
    output logic [ADDR_W-1:0] cur_ptr_o,
    output logic [ADDR_W-1:0] trig_ptr_o,
    output logic              done_o
);
    logic wr_en, trig_hit, clr;

    capctl_seq #(.DLY_W(DLY_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm_i),
        .wsm_rst_i  (wsm_rst_i),
        .trig_i     (trig_i),
        .smp_vld_i  (smp_vld_i),
        .delay_i    (delay_i),
        .wr_en_o    (wr_en),
        .trig_hit_o (trig_hit),
        .clr_o      (clr),
        .done_o     (done_o)
    );

    capctl_ptr #(.ADDR_W(ADDR_W)) ptr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .trig_hit_i (trig_hit),
        .clr_i      (clr),
        .cur_o      (cur_ptr_o),
        .trig_o     (trig_ptr_o)
    );

    assign wr_en_o   = wr_en;
    assign wr_addr_o = cur_ptr_o;
    assign wr_a_o    = ch_a_i;
    assign wr_b_o    = ch_b_i;

    // R2: writes only on sample-valid cycles, never during a reset request
    a_r2_vld_gate: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (smp_vld_i && !wsm_rst_i));
endmodule

// File: tb/capture_ctrl_tb_top.sv
`timescale 1ns/100ps
module capture_ctrl_tb_top;
    localparam int AW = 4;
    localparam int DW = 14;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0, wrst = 1'b0, trig = 1'b0, vld = 1'b0;
    logic [LW-1:0] delay = '0;
    logic [DW-1:0] cha = '0, chb = '0;
    logic          wr_en, done;
    logic [AW-1:0] wr_addr, cur_ptr, trig_ptr;
    logic [DW-1:0] wr_a, wr_b;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    capture_ctrl #(.ADDR_W(AW), .DATA_W(DW), .DLY_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .wsm_rst_i(wrst), .delay_i(delay),
        .smp_vld_i(vld), .ch_a_i(cha), .ch_b_i(chb), .trig_i(trig),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_a_o(wr_a), .wr_b_o(wr_b),
        .cur_ptr_o(cur_ptr), .trig_ptr_o(trig_ptr), .done_o(done)
    );

    typedef struct packed {
        logic          arm;
        logic          rst;
        logic          trg;
        logic          vld;
        logic          e_wr;
        logic [AW-1:0] e_addr;
        logic [AW-1:0] e_tptr;
        logic          e_done;
    } vec_t;

    // delay fixed at 2 during the table
    localparam vec_t VEC [14] = '{
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 4'd0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 4'd0, 1'b0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd1, 4'd0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'd1, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2, 4'd1, 1'b0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3, 4'd1, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4, 4'd1, 1'b0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd4, 4'd1, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4, 4'd1, 1'b1},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4, 4'd1, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5, 4'd1, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive inputs away from the edge, then let combinational outputs settle
    task automatic step(input logic a, input logic r, input logic t, input logic v);
        @(negedge clk);
        arm = a; wrst = r; trig = t; vld = v;
        cha = cha + 14'd3; chb = chb - 14'd5;
        #1;
    endtask

    task automatic sw_reset();
        step(1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #(5 * 20000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R1 wr_en", {31'b0, wr_en}, 0);
        chk("R1 cur_ptr", {28'b0, cur_ptr}, 0);
        chk("R1 trig_ptr", {28'b0, trig_ptr}, 0);
        chk("R1 done", {31'b0, done}, 0);

        // vector table: R2, R4, R5, R6, R7, R8
        delay = LW'(2);
        for (int i = 0; i < 14; i++) begin
            step(VEC[i].arm, VEC[i].rst, VEC[i].trg, VEC[i].vld);
            chk($sformatf("R2/R5 wr_en row %0d", i), {31'b0, wr_en}, {31'b0, VEC[i].e_wr});
            chk($sformatf("R3 addr row %0d", i), {28'b0, wr_addr}, {28'b0, VEC[i].e_addr});
            chk($sformatf("R4/R8 trig_ptr row %0d", i), {28'b0, trig_ptr}, {28'b0, VEC[i].e_tptr});
            chk($sformatf("R6 done row %0d", i), {31'b0, done}, {31'b0, VEC[i].e_done});
            if (wr_en) begin
                chk("R2 data a", {18'b0, wr_a}, {18'b0, cha});
                chk("R2 data b", {18'b0, wr_b}, {18'b0, chb});
            end
        end

        // R7: trigger while idle is ignored
        sw_reset();
        step(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R7 idle trig no write", {31'b0, wr_en}, 0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 idle trig_ptr", {28'b0, trig_ptr}, 0);
        chk("R7 idle cur_ptr", {28'b0, cur_ptr}, 0);

        // R3/R5: long delay across wrap, gapped strobe
        begin
            int mptr = 0, post_wr = 0, rem = 0, exp_t = 0;
            bit marm = 1, mpost = 0;
            delay = LW'(20);
            sw_reset();
            step(1'b1, 1'b0, 1'b0, 1'b0);
            for (int i = 0; i < 60; i++) begin
                logic v, t, ew;
                v = (i % 3) != 2;
                t = (i == 5);
                step(1'b0, 1'b0, t, v);
                ew = v && (marm || (mpost && rem > 0));
                chk("R3/R5 wrap wr_en", {31'b0, wr_en}, {31'b0, ew});
                if (ew) chk("R3 wrap addr", {28'b0, wr_addr}, mptr);
                if (marm && t) begin
                    exp_t = mptr; marm = 0; mpost = 1; rem = 20;
                end else if (mpost) begin
                    if (rem == 0) mpost = 0;
                    else if (v) begin rem--; post_wr++; end
                end
                if (ew) mptr = (mptr + 1) % 16;
            end
            step(1'b0, 1'b0, 1'b0, 1'b0);
            chk("R5 post-trigger writes", post_wr, 20);
            chk("R5 done after delay", {31'b0, done}, 1);
            chk("R4 wrap trig_ptr", {28'b0, trig_ptr}, exp_t);
            chk("R3 final cur_ptr", {28'b0, cur_ptr}, mptr);
        end

        // R5: zero delay
        delay = '0;
        sw_reset();
        step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R5 zero delay trigger-cycle write", {31'b0, wr_en}, 1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R5 zero delay no more writes", {31'b0, wr_en}, 0);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R5 zero delay done", {31'b0, done}, 1);

        // R9: arm while counting does not reload
        begin
            int wcnt = 0;
            delay = LW'(3);
            sw_reset();
            step(1'b1, 1'b0, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b1, 1'b1);
            for (int k = 0; k < 5; k++) begin
                step(k < 3, 1'b0, 1'b0, 1'b1);
                if (wr_en) wcnt++;
            end
            chk("R9 arm ignored, writes", wcnt, 3);
            chk("R9 done reached", {31'b0, done}, 1);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule